// File: doc/BRIEF.md
# Count-to-Thermometer Threshold Decoder

This block sits behind a ones counter. It takes the binary count of set inputs and produces one threshold flag for every value q from 1 to N. Flag q is high exactly when the count is at least q. The flags together form the sorted 0/1 image of the original inputs: a thermometer code with its ones packed into the low positions. A separate majority flag reports whether at least half the inputs, rounded up, are set.

Each flag is built from a ladder of single two-input gates, one count bit per rung. The constant q chooses the gate on every rung. A zero bit of q selects OR and a one bit selects AND. The ladder is shared across the flags. Every entry at a rung is one gate fed by the count bit of that rung and one entry from the rung below. Because of this sharing the gate count grows in proportion to N. No magnitude comparator appears anywhere. The block is purely combinational. Counts above N are never produced by the counter, and nothing is promised for them.

Top module: `count_thermo_decoder`

## Requirements
- R1: For every count c in 0..N and every q in 1..N, `level_out[q-1]` is 1 exactly when c >= q. Bit q-1 of the vector carries threshold q.
- R2: A count of 0 drives every bit of `level_out` to 0 and drives `median_out` to 0.
- R3: A count equal to N drives every bit of `level_out` to 1.
- R4: For every count in 0..N, `level_out` is a thermometer code. No 1 appears at a bit position above a 0.
- R5: For every count c in 0..N, the number of ones in `level_out` equals c.
- R6: `median_out` is 1 exactly when the count is at least ceil(N/2), computed as (N+1)/2 in integer division.
- R7: When the count is an exact power of two 2^t, flag 2^t (bit 2^t-1) is 1. Flag 2^t+1 (bit 2^t) is 0 whenever that flag exists.
- R8: The outputs depend only on the present count and hold no state. The outputs for a count are the same whichever count came before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| count_in | input | $clog2(N+1) | Binary count of set inputs, 0..N |
| level_out | output | N | Threshold flags; bit q-1 is high when count_in >= q |
| median_out | output | 1 | Majority flag: count_in >= ceil(N/2) |

## Verification
The bench builds two copies of the block. The first uses N=15, which fills the count width. Every ladder rung is then complete, and every power-of-two threshold, including the topmost, is reached. The second uses N=10. There the final rung is cut short, counts 11 to 15 are never applied, and the majority threshold of 5 is odd and lies off a power of two. Both copies are swept upward and then downward through all legal counts, so every flag is seen to rise and to fall.

// File: rtl/thr_pkg.sv
package thr_pkg;

    // Number of bits needed to carry a count from 0 up to n.
    function automatic int count_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // Majority threshold: ceil(n/2).
    function automatic int majority_q(input int n);
        return (n + 1) / 2;
    endfunction

    // Start of rung t inside the flat ladder table (rungs hold 1,2,4,... entries).
    function automatic int rung_base(input int t);
        return (1 << t) - 1;
    endfunction

endpackage

// File: rtl/thr_cell.sv
// One rung gate: joins a count bit with an entry from the rung below.
module thr_cell #(
    parameter bit JOIN_AND = 1'b0
) (
    input  logic a_bit,
    input  logic b_prev,
    output logic y
);
    generate
        if (JOIN_AND) begin : g_and
            assign y = a_bit & b_prev;
        end else begin : g_or
            assign y = a_bit | b_prev;
        end
    endgenerate
endmodule

// File: rtl/thr_rung.sv
// One rung of the ladder. Entry r compares the low bits of the count with r.
// Entries below IN_W OR in this rung's count bit; the rest AND it with
// the entry r-IN_W of the rung below.
module thr_rung #(
    parameter int IN_W  = 1,
    parameter int START = 0,
    parameter int OUT_W = 2
) (
    input  logic [IN_W-1:0]  prev,
    input  logic             dbit,
    output logic [OUT_W-1:0] nxt
);
    generate
        for (genvar k = 0; k < OUT_W; k++) begin : g_ent
            localparam int R = START + k;
            if (R < IN_W) begin : g_low
                thr_cell #(.JOIN_AND(1'b0)) u_cell (
                    .a_bit (dbit),
                    .b_prev(prev[R]),
                    .y     (nxt[k])
                );
            end else begin : g_high
                localparam int RL = R - IN_W;
                thr_cell #(.JOIN_AND(1'b1)) u_cell (
                    .a_bit (dbit),
                    .b_prev(prev[RL]),
                    .y     (nxt[k])
                );
            end
        end
    endgenerate
endmodule

// File: rtl/count_thermo_decoder.sv
module count_thermo_decoder
    import thr_pkg::*;
#(
    parameter int N = 15
) (
    input  logic [thr_pkg::count_width(N)-1:0] count_in,
    output logic [N-1:0]                       level_out,
    output logic                               median_out
);
    localparam int CW    = count_width(N);
    localparam int TOP   = CW - 1;
    localparam int TAB_W = (1 << CW) - 1;
    localparam int MAJ   = majority_q(N);

    // Rungs 0..TOP, rung t holds 2^t entries starting at rung_base(t).
    logic [TAB_W-1:0] tab;

    assign tab[0] = 1'b1;

    generate
        for (genvar t = 0; t < TOP; t++) begin : g_mid
            thr_rung #(
                .IN_W (1 << t),
                .START(0),
                .OUT_W(1 << (t + 1))
            ) u_rung (
                .prev(tab[rung_base(t) +: (1 << t)]),
                .dbit(count_in[t]),
                .nxt (tab[rung_base(t + 1) +: (1 << (t + 1))])
            );
        end
    endgenerate

    // Last rung: only thresholds 1..N are kept.
    thr_rung #(
        .IN_W (1 << TOP),
        .START(1),
        .OUT_W(N)
    ) u_last (
        .prev(tab[rung_base(TOP) +: (1 << TOP)]),
        .dbit(count_in[TOP]),
        .nxt (level_out)
    );

    assign median_out = level_out[MAJ-1];

endmodule

// File: rtl/thr_check.sv
module thr_check
    import thr_pkg::*;
#(
    parameter int N = 15
) (
    input logic [thr_pkg::count_width(N)-1:0] count_in,
    input logic [N-1:0]                       level_out,
    input logic                               median_out
);
    localparam int MAJ = majority_q(N);

    always_comb begin
        if (int'(count_in) <= N) begin
            for (int q = 1; q <= N; q++) begin
                assert_flag_matches_R1: assert (level_out[q-1] == (int'(count_in) >= q))
                    else $error("flag %0d wrong for count %0d", q, count_in);
            end
            for (int b = 1; b < N; b++) begin
                assert_thermometer_R4: assert (!(level_out[b] && !level_out[b-1]))
                    else $error("gap below bit %0d", b);
            end
            assert_popcount_R5: assert ($countones(level_out) == int'(count_in))
                else $error("ones %0d vs count %0d", $countones(level_out), count_in);
            assert_majority_R6: assert (median_out == (int'(count_in) >= MAJ))
                else $error("majority flag wrong for count %0d", count_in);
            if (count_in == '0) begin
                assert_zero_clear_R2: assert (level_out == '0 && !median_out)
                    else $error("outputs not clear at zero");
            end
        end
    end
endmodule

bind count_thermo_decoder thr_check #(.N(N)) u_chk (
    .count_in  (count_in),
    .level_out (level_out),
    .median_out(median_out)
);

// File: tb/sim_count_thermo_decoder.sv
`timescale 1ns/1ps
module sim_count_thermo_decoder;
    localparam int NA = 15;
    localparam int NB = 10;
    localparam int CWA = $clog2(NA + 1);
    localparam int CWB = $clog2(NB + 1);

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [CWA-1:0] cnt_a = '0;
    logic [CWB-1:0] cnt_b = '0;
    logic [NA-1:0]  lvl_a;
    logic [NB-1:0]  lvl_b;
    logic           med_a, med_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    count_thermo_decoder #(.N(NA)) u0 (.count_in(cnt_a), .level_out(lvl_a), .median_out(med_a));
    count_thermo_decoder #(.N(NB)) u1 (.count_in(cnt_b), .level_out(lvl_b), .median_out(med_b));

    task automatic chk(input string req, input longint act, input longint exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference model: thresholds from integer comparison, nothing shared with the RTL.
    task automatic judge(input int n, input int c, input longint vec, input bit med);
        longint exp = 0;
        int ones = 0;
        bit mono = 1'b1;
        for (int q = 1; q <= n; q++) if (c >= q) exp |= (64'd1 << (q - 1));
        chk("R1", vec, exp, $sformatf("vector n=%0d c=%0d", n, c));
        for (int b = 0; b < n; b++) begin
            ones += int'(vec[b]);
            if (b > 0 && vec[b] && !vec[b-1]) mono = 1'b0;
        end
        chk("R4", mono, 1, $sformatf("thermometer n=%0d c=%0d", n, c));
        chk("R5", ones, c, $sformatf("popcount n=%0d", n));
        chk("R6", med, (c >= (n + 1) / 2), $sformatf("majority n=%0d c=%0d", n, c));
        if (c == 0) chk("R2", {vec, med}, 0, $sformatf("all clear n=%0d", n));
        if (c == n) chk("R3", vec, (64'd1 << n) - 1, $sformatf("all set n=%0d", n));
        for (int t = 0; (1 << t) <= n; t++) begin
            if (c == (1 << t)) begin
                chk("R7", vec[(1 << t) - 1], 1, $sformatf("flag 2^%0d n=%0d", t, n));
                if ((1 << t) < n) chk("R7", vec[1 << t], 0, $sformatf("flag 2^%0d+1 n=%0d", t, n));
            end
        end
    endtask

    task automatic apply(input int ca, input int cb);
        @(posedge clk);
        cnt_a <= CWA'(ca);
        cnt_b <= CWB'(cb);
        @(negedge clk);
        judge(NA, ca, longint'(lvl_a), med_a);
        judge(NB, cb, longint'(lvl_b), med_b);
    endtask

    initial begin
        // Reset state: counts start at zero.
        @(negedge clk);
        judge(NA, 0, longint'(lvl_a), med_a);
        judge(NB, 0, longint'(lvl_b), med_b);
        for (int c = 0; c <= NA; c++) apply(c, (c <= NB) ? c : NB);
        for (int c = NA; c >= 0; c--) apply(c, (c <= NB) ? c : 0);
        // R8: the same count after very different predecessors gives the same outputs.
        apply(NA, NB); apply(5, 5);
        apply(0, 0);   apply(5, 5);
        apply(12, 9);  apply(3, 1);  apply(8, 4);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8ns * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule